// File: doc/BRIEF.md
# I2C EEPROM Boot Fetch Engine

This block loads a boot image out of a serial EEPROM on a two-wire bus. A host places two 32-bit configuration words and a byte count on the inputs, then pulses a go strobe. The first word carries a fixed header code, an enable bit for the serial port, a 12-bit SCL rate divider and the seven-bit device code that goes out as the first bus byte. The second word carries the 16-bit memory address where reading starts. A bad header or a cleared port bit ends the request at once with the error flag raised, and the bus is never touched.

With an accepted message the engine runs one random-address sequential read. It sends a START and the device code with the write bit, then both address bytes. A repeated START and the device code with the read bit follow, and then it clocks in the requested bytes. The bus outputs are open-drain enables: a 1 pulls the line low. Each received byte is offered on a valid/ready stream. SCL stays low until the byte is taken, so a slow consumer simply stretches the transfer. When the transfer ends, done or error stays set until the next accepted go.

Top module: `i2c_boot_fetch`

## Requirements
- R1: A go pulse in idle with word0 bits 31:21 not equal to 11'b11000000000 sets error, leaves done at 0, and produces no SCL or SDA activity.
- R2: A go pulse in idle with word0 bit 20 at 0 is rejected in the same way as R1.
- R3: Each SCL high and low half-period of a bit lasts (d+1) clock cycles, where d is word0 bits 19:8, and a value of 0 counts as 1.
- R4: The bus carries, in order: START, {word0[6:0],1'b0}, word1[15:8], word1[7:0], repeated START, {word0[6:0],1'b1}. Every byte is sent MSB first.
- R5: Data bytes are assembled MSB first from SDA sampled at the end of each SCL high half. Each byte is held on rx_data with rx_valid high until rx_ready, and SCL is held low meanwhile.
- R6: Every data byte except the last is acknowledged (SDA low on the ninth clock). The last byte gets SDA released, then a STOP follows and done is set.
- R7: If the slave leaves SDA high in the acknowledge slot of the device byte or of either address byte, the engine issues STOP, sets error and delivers no data.
- R8: A byte count of 0 is read as one byte.
- R9: After reset, and after any reset during a transfer, both bus lines are released, and busy, rx_valid, done and error are 0.
- R10: During a transfer, SDA changes while SCL is high only for the START, repeated START and STOP conditions.
- R11: A go pulse while busy is ignored. The transfer in progress keeps its address, device code and rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| boot_go | input | 1 | One-cycle request to start a fetch |
| msg_word0 | input | 32 | First configuration word: header, port bit, divider, device code |
| msg_word1 | input | 32 | Second configuration word: start address in bits 15:0 |
| read_len | input | 16 | Number of bytes to read (0 means 1) |
| scl_drive_low | output | 1 | Pull SCL low when 1, release when 0 |
| sda_drive_low | output | 1 | Pull SDA low when 1, release when 0 |
| sda_in | input | 1 | Sensed level of the SDA line |
| rx_data | output | 8 | Received data byte |
| rx_valid | output | 1 | rx_data holds a byte not yet taken |
| rx_ready | input | 1 | Consumer accepts the byte in this cycle |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | Last fetch finished cleanly |
| error | output | 1 | Last fetch was rejected or aborted |

## Verification
A wrong phase or bit counter in the sequencer shows up within one byte time on the bus. A model slave decodes the bus edges, so it sees extra or missing START and STOP conditions or a shifted address byte. It then returns data from the wrong location, and that shows on rx_data at the next handshake. A bad divider register shows as a wrong SCL high time on the very first data bit. A mis-decoded header shows at once as wrong error or done flags, or as SCL edges where none should appear. A bad remaining-count register shows as a wrong number of bytes or a missing NACK and STOP at the end of the read.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  localparam int HDR_W = 11;
  localparam logic [HDR_W-1:0] HDR_CODE = 11'b110_0000_0000;
  localparam int ADDR_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_TX,
    ST_RX,
    ST_HOLD,
    ST_MACK,
    ST_STOP
  } bus_st_e;
endpackage

// File: rtl/i2cb_msg_decode.sv
module i2cb_msg_decode
  import i2cb_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic [31:0]       word0,
  input  logic [31:0]       word1,
  output logic              cfg_ok,
  output logic [DIV_W-1:0]  div_eff,
  output logic [6:0]        dev_code,
  output logic [ADDR_W-1:0] start_addr
);
  localparam int DIV_LSB  = 8;
  localparam int PORT_BIT = DIV_LSB + DIV_W;
  localparam int HDR_LSB  = 32 - HDR_W;

  logic [DIV_W-1:0] div_raw;
  logic             unused_bits;

  assign div_raw     = word0[DIV_LSB +: DIV_W];
  assign cfg_ok      = (word0[31:HDR_LSB] == HDR_CODE) && word0[PORT_BIT];
  assign div_eff     = (div_raw == '0) ? DIV_W'(1) : div_raw;
  assign dev_code    = word0[6:0];
  assign start_addr  = word1[ADDR_W-1:0];
  assign unused_bits = ^{word1[31:ADDR_W], word0[7], word0[HDR_LSB-1:PORT_BIT+1]};
endmodule

// File: rtl/i2cb_tick.sv
module i2cb_tick #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = '0;
    if (run && (cnt_q != limit)) cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == limit);

  // R3: the half-period counter never passes its limit
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= limit));
endmodule

// File: rtl/i2c_boot_fetch.sv
module i2c_boot_fetch
  import i2cb_pkg::*;
#(
  parameter int DIV_W = 12,
  parameter int LEN_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boot_go,
  input  logic [31:0] msg_word0,
  input  logic [31:0] msg_word1,
  input  logic [LEN_W-1:0] read_len,
  output logic        scl_drive_low,
  output logic        sda_drive_low,
  input  logic        sda_in,
  output logic [7:0]  rx_data,
  output logic        rx_valid,
  input  logic        rx_ready,
  output logic        busy,
  output logic        done,
  output logic        error
);
  localparam logic [3:0] ACK_SLOT = 4'd8;

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic              cfg_ok;
  logic [DIV_W-1:0]  dec_div;
  logic [6:0]        dec_code;
  logic [ADDR_W-1:0] dec_addr;

  i2cb_msg_decode #(.DIV_W(DIV_W)) u_dec (
    .word0(msg_word0), .word1(msg_word1), .cfg_ok(cfg_ok),
    .div_eff(dec_div), .dev_code(dec_code), .start_addr(dec_addr)
  );

  bus_st_e           st_q, st_d;
  logic [1:0]        ph_q, ph_d;
  logic [3:0]        bit_q, bit_d;
  logic [7:0]        sh_q, sh_d;
  logic [1:0]        idx_q, idx_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [6:0]        code_q, code_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              fail_q, fail_d, done_q, done_d, err_q, err_d;
  logic              tick, tick_run;
  logic [1:0]        last_ph;

  assign tick_run = (st_q != ST_IDLE) && (st_q != ST_HOLD);

  i2cb_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_core_n), .run(tick_run), .limit(div_q), .tick(tick)
  );

  assign last_ph = ((st_q == ST_START) || (st_q == ST_STOP)) ? 2'd2 : 2'd1;

  always_comb begin
    st_d = st_q;   ph_d = ph_q;     bit_d = bit_q;   sh_d = sh_q;
    idx_d = idx_q; left_d = left_q; div_d = div_q;   code_d = code_q;
    addr_d = addr_q; fail_d = fail_q; done_d = done_q; err_d = err_q;
    if (st_q == ST_IDLE) begin
      if (boot_go) begin
        done_d = 1'b0;
        err_d  = !cfg_ok;
        if (cfg_ok) begin
          div_d  = dec_div;
          code_d = dec_code;
          addr_d = dec_addr;
          left_d = (read_len == '0) ? LEN_W'(1) : read_len;
          idx_d  = 2'd0;
          fail_d = 1'b0;
          ph_d   = 2'd0;
          st_d   = ST_START;
        end
      end
    end else if (st_q == ST_HOLD) begin
      if (rx_ready) begin
        st_d = ST_MACK;
        ph_d = 2'd0;
      end
    end else if (tick) begin
      if (ph_q != last_ph) begin
        ph_d = ph_q + 2'd1;
      end else begin
        ph_d = 2'd0;
        case (st_q)
          ST_START: begin
            st_d  = ST_TX;
            bit_d = 4'd0;
            sh_d  = {code_q, idx_q == 2'd3};
          end
          ST_TX: begin
            if (bit_q != ACK_SLOT) begin
              sh_d  = {sh_q[6:0], 1'b0};
              bit_d = bit_q + 4'd1;
            end else if (sda_in) begin
              fail_d = 1'b1;
              st_d   = ST_STOP;
            end else begin
              bit_d = 4'd0;
              case (idx_q)
                2'd0:    begin idx_d = 2'd1; sh_d = addr_q[15:8]; end
                2'd1:    begin idx_d = 2'd2; sh_d = addr_q[7:0];  end
                2'd2:    begin idx_d = 2'd3; st_d = ST_START;     end
                default: st_d = ST_RX;
              endcase
            end
          end
          ST_RX: begin
            sh_d = {sh_q[6:0], sda_in};
            if (bit_q == 4'd7) st_d = ST_HOLD;
            else               bit_d = bit_q + 4'd1;
          end
          ST_MACK: begin
            if (left_q == LEN_W'(1)) begin
              st_d = ST_STOP;
            end else begin
              left_d = left_q - LEN_W'(1);
              bit_d  = 4'd0;
              st_d   = ST_RX;
            end
          end
          default: begin
            st_d   = ST_IDLE;
            done_d = !fail_q;
            err_d  = fail_q;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      st_q <= ST_IDLE;  ph_q <= '0;   bit_q <= '0;  sh_q <= '0;
      idx_q <= '0;      left_q <= '0; div_q <= '0;  code_q <= '0;
      addr_q <= '0;     fail_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      st_q <= st_d;     ph_q <= ph_d;     bit_q <= bit_d;   sh_q <= sh_d;
      idx_q <= idx_d;   left_q <= left_d; div_q <= div_d;   code_q <= code_d;
      addr_q <= addr_d; fail_q <= fail_d; done_q <= done_d; err_q <= err_d;
    end
  end

  always_comb begin
    scl_drive_low = 1'b0;
    sda_drive_low = 1'b0;
    case (st_q)
      ST_START: begin scl_drive_low = (ph_q == 2'd0); sda_drive_low = (ph_q == 2'd2); end
      ST_TX:    begin scl_drive_low = (ph_q == 2'd0); sda_drive_low = (bit_q != ACK_SLOT) && !sh_q[7]; end
      ST_RX:    scl_drive_low = (ph_q == 2'd0);
      ST_HOLD:  scl_drive_low = 1'b1;
      ST_MACK:  begin scl_drive_low = (ph_q == 2'd0); sda_drive_low = (left_q != LEN_W'(1)); end
      ST_STOP:  begin scl_drive_low = (ph_q == 2'd0); sda_drive_low = (ph_q != 2'd2); end
      default:  ;
    endcase
  end

  assign rx_data  = sh_q;
  assign rx_valid = (st_q == ST_HOLD);
  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
  assign error    = err_q;

  p_cfg_reject_r1_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (st_q == ST_IDLE && boot_go && !cfg_ok) |=> (error && !done && !busy));

  p_idle_release_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    !busy |-> (!scl_drive_low && !sda_drive_low));

  p_hold_stall_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && scl_drive_low));

  p_sda_quiet_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!scl_drive_low && !$past(scl_drive_low) && $past(st_q) == st_q &&
     (st_q == ST_TX || st_q == ST_RX || st_q == ST_MACK)) |-> $stable(sda_drive_low));

  p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(done && error));

  p_nack_stop_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (st_q == ST_TX && tick && ph_q == 2'd1 && bit_q == ACK_SLOT && sda_in) |=> (st_q == ST_STOP));

  p_go_ignored_r11: assert property (@(posedge clk) disable iff (!rst_core_n)
    (busy && boot_go) |=> ($stable(addr_q) && $stable(code_q) && $stable(div_q)));
endmodule

// File: tb/sim_i2c_boot_fetch.sv
`timescale 1ns/1ps
module sim_i2c_boot_fetch;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        boot_go;
  logic [31:0] msg_word0, msg_word1;
  logic [15:0] read_len;
  logic        scl_dl, sda_dl, sda_in;
  logic [7:0]  rx_data;
  logic        rx_valid, rx_ready, busy, done, error;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;

  always #2.5 clk = ~clk;

  i2c_boot_fetch u0 (
    .clk(clk), .rst_n(rst_n), .boot_go(boot_go), .msg_word0(msg_word0),
    .msg_word1(msg_word1), .read_len(read_len), .scl_drive_low(scl_dl),
    .sda_drive_low(sda_dl), .sda_in(sda_in), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .busy(busy), .done(done), .error(error)
  );

  function automatic logic [7:0] memb(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'h3C;
  endfunction

  // ---------------- model slave on the open-drain bus ----------------
  localparam int S_IDLE = 0, S_RX = 1, S_ACK = 2, S_TX = 3, S_MACK = 4;
  logic       s_drv;
  logic       scl_bus, sda_bus, p_scl, p_sda, rd_mode, ackd;
  logic [7:0] s_sh;
  logic [15:0] ptr;
  int s_st, bitc, fi, rxn, n_start, n_stop, n_fall, hi_run, hi_len;
  logic [1:0] nack_at;
  logic [7:0] rxlog [4];

  assign scl_bus = !scl_dl;
  assign sda_bus = !(sda_dl || s_drv);
  assign sda_in  = sda_bus;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_drv <= 1'b0; p_scl <= 1'b1; p_sda <= 1'b1; s_st <= S_IDLE;
      bitc <= 0; fi <= 0; hi_run <= 0; ackd <= 1'b0; rd_mode <= 1'b0;
    end else begin
      p_scl <= scl_bus;
      p_sda <= sda_bus;
      hi_run <= scl_bus ? hi_run + 1 : 0;
      if (p_scl && !scl_bus) begin
        n_fall <= n_fall + 1;
        if (s_st == S_TX) hi_len <= hi_run;
      end
      if (p_scl && scl_bus && p_sda && !sda_bus) begin
        n_start <= n_start + 1; s_st <= S_RX; bitc <= 0; fi <= 0; s_drv <= 1'b0;
      end else if (p_scl && scl_bus && !p_sda && sda_bus) begin
        n_stop <= n_stop + 1; s_st <= S_IDLE; s_drv <= 1'b0;
      end else if (!p_scl && scl_bus) begin
        if (s_st == S_RX)   begin s_sh <= {s_sh[6:0], sda_bus}; bitc <= bitc + 1; end
        if (s_st == S_TX)   bitc <= bitc + 1;
        if (s_st == S_MACK) ackd <= !sda_bus;
      end else if (p_scl && !scl_bus) begin
        case (s_st)
          S_RX: if (bitc == 8) begin
            logic ok;
            ok = (rxn + 1 != int'(nack_at));
            if (rxn < 4) rxlog[rxn] <= s_sh;
            rxn <= rxn + 1;
            if (fi == 0) begin rd_mode <= s_sh[0]; ok = ok && (s_sh[7:1] == 7'h50); end
            else if (fi == 1) ptr[15:8] <= s_sh;
            else if (fi == 2) ptr[7:0]  <= s_sh;
            fi <= fi + 1;
            if (ok) begin s_drv <= 1'b1; s_st <= S_ACK; end
            else s_st <= S_IDLE;
          end
          S_ACK: begin
            bitc <= 0;
            if (rd_mode) begin s_sh <= memb(ptr); s_drv <= !memb(ptr)[7]; s_st <= S_TX; end
            else begin s_drv <= 1'b0; s_st <= S_RX; end
          end
          S_TX: begin
            if (bitc == 8) begin s_drv <= 1'b0; s_st <= S_MACK; end
            else s_drv <= !s_sh[7 - bitc];
          end
          S_MACK: begin
            if (ackd) begin
              ptr <= ptr + 16'd1; s_sh <= memb(ptr + 16'd1);
              s_drv <= !memb(ptr + 16'd1)[7]; bitc <= 0; s_st <= S_TX;
            end else s_st <= S_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  // ---------------- stream sink with stalls ----------------
  logic [7:0] rbuf [8];
  int got, stall_bad;
  logic pv, pr;
  logic [7:0] pd;
  always @(negedge clk) begin
    logic rdy;
    rdy = (cyc % 3) == 0;
    if (pv && !pr && rx_valid && rx_data != pd) stall_bad = stall_bad + 1;
    rx_ready = rdy;
    if (rx_valid && rdy) begin
      if (got < 8) rbuf[got] = rx_data;
      got = got + 1;
    end
    pv = rx_valid; pr = rdy; pd = rx_data;
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      vectors = vectors + 1; fails = fails + 1;
      $display("FAIL watchdog (all requirements) act=%0d exp=<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors = vectors + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic kick(input logic [31:0] w0, input logic [15:0] a, input logic [15:0] n,
                      input logic [1:0] nk);
    @(negedge clk);
    msg_word0 = w0; msg_word1 = {16'h0, a}; read_len = n; nack_at = nk;
    got = 0; stall_bad = 0; rxn = 0; n_start = 0; n_stop = 0; n_fall = 0; hi_len = -1;
    boot_go = 1'b1;
    @(negedge clk);
    boot_go = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // word0, addr, count, nack slot, expected error
  localparam logic [66:0] VEC [10] = '{
    {32'hC010_0350, 16'h1234, 16'd3, 2'd0, 1'b0},
    {32'hC010_0050, 16'h00FF, 16'd1, 2'd0, 1'b0},
    {32'hC010_0150, 16'hFFFE, 16'd4, 2'd0, 1'b0},
    {32'hC010_0550, 16'h0A0B, 16'd0, 2'd0, 1'b0},
    {32'hC030_0350, 16'h1111, 16'd2, 2'd0, 1'b1},
    {32'hC000_0350, 16'h2222, 16'd2, 2'd0, 1'b1},
    {32'hC010_0250, 16'h3333, 16'd2, 2'd1, 1'b1},
    {32'hC010_0250, 16'h4444, 16'd2, 2'd2, 1'b1},
    {32'hC010_0250, 16'h5555, 16'd2, 2'd3, 1'b1},
    {32'hC010_0250, 16'h8000, 16'd2, 2'd0, 1'b0}
  };

  initial begin
    rst_n = 1'b0; boot_go = 1'b0; msg_word0 = '0; msg_word1 = '0; read_len = '0;
    nack_at = 2'd0; rx_ready = 1'b0; got = 0; stall_bad = 0; pv = 0; pr = 0; pd = '0;
    n_start = 0; n_stop = 0; n_fall = 0; rxn = 0; hi_len = 0; ptr = '0; s_sh = '0;
    repeat (4) @(negedge clk);
    // R9: reset state
    chk(!scl_dl && !sda_dl, "R9 lines released in reset", {scl_dl, sda_dl}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !rx_valid, "R9 busy/valid after reset", {busy, rx_valid}, 0);
    chk(!done && !error, "R9 flags after reset", {done, error}, 0);
    chk(!scl_dl && !sda_dl, "R9 lines after reset", {scl_dl, sda_dl}, 0);

    for (int v = 0; v < 10; v++) begin
      logic [31:0] w0;
      logic [15:0] a, n;
      logic [1:0]  nk;
      logic        experr, cfg_bad;
      int          expn, half;
      {w0, a, n, nk, experr} = VEC[v];
      cfg_bad = (w0[31:21] != 11'b110_0000_0000) || !w0[20];
      expn = (n == 0) ? 1 : int'(n);
      half = (w0[19:8] == 0) ? 2 : int'(w0[19:8]) + 1;
      kick(w0, a, n, nk);
      wait_idle();
      if (cfg_bad) begin
        chk(error == 1'b1, w0[20] ? "R1 error on bad header" : "R2 error on port bit 0", error, 1);
        chk(done == 1'b0, "R1 done stays low", done, 0);
        chk(n_fall == 0, "R1 no SCL activity", n_fall, 0);
      end else if (experr) begin
        chk(error && !done, "R7 error on slave NACK", {done, error}, 1);
        chk(got == 0, "R7 no data delivered", got, 0);
        chk(n_stop == 1, "R7 STOP issued", n_stop, 1);
      end else begin
        chk(done && !error, "R6 done after read", {done, error}, 2);
        chk(got == expn, (n == 0) ? "R8 zero count reads one" : "R6 byte count", got, expn);
        for (int i = 0; i < expn && i < 8; i++)
          chk(rbuf[i] == memb(a + 16'(i)), "R5 data byte", rbuf[i], memb(a + 16'(i)));
        chk(hi_len == half, "R3 SCL high time", hi_len, half);
        chk(rxlog[0] == {w0[6:0], 1'b0}, "R4 write device byte", rxlog[0], {w0[6:0], 1'b0});
        chk(rxlog[1] == a[15:8], "R4 address high", rxlog[1], a[15:8]);
        chk(rxlog[2] == a[7:0], "R4 address low", rxlog[2], a[7:0]);
        chk(rxlog[3] == {w0[6:0], 1'b1}, "R4 read device byte", rxlog[3], {w0[6:0], 1'b1});
        chk(n_start == 2 && n_stop == 1, "R10 only START/RSTART/STOP edges", n_start * 16 + n_stop, 33);
        chk(stall_bad == 0, "R5 byte held during stall", stall_bad, 0);
      end
    end

    // R11: go while busy is ignored
    kick(32'hC010_0250, 16'h1234, 16'd2, 2'd0);
    repeat (150) @(negedge clk);
    chk(busy == 1'b1, "R11 transfer running", busy, 1);
    msg_word0 = 32'hC010_0051; msg_word1 = 32'h0000_7777; boot_go = 1'b1;
    @(negedge clk);
    boot_go = 1'b0;
    wait_idle();
    chk(got == 2 && rbuf[0] == memb(16'h1234) && rbuf[1] == memb(16'h1235),
        "R11 data from original address", rbuf[0], memb(16'h1234));
    chk(rxlog[3] == 8'hA1, "R11 device code unchanged", rxlog[3], 8'hA1);

    // R9: reset in the middle of a transfer, then recovery
    kick(32'hC010_0350, 16'h0F0F, 16'd3, 2'd0);
    repeat (200) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !rx_valid && !scl_dl && !sda_dl, "R9 mid-transfer reset",
        {busy, rx_valid, scl_dl, sda_dl}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    kick(32'hC010_0150, 16'h0F0F, 16'd2, 2'd0);
    wait_idle();
    chk(done && got == 2 && rbuf[1] == memb(16'h0F10), "R9 recovery read", rbuf[1], memb(16'h0F10));

    summary();
    $finish;
  end
endmodule